// File: doc/BRIEF.md
# Conditional Select and Compare Unit

This unit carries out the handful of condition-driven operations left to an instruction set that has no general predication. Each operation takes two operands and a 4-bit condition code. The condition is tested against the current N, Z, C and V flags. The operation then either picks between operand A and a transformed operand B, materialises a boolean or mask value, or chooses the next flag state.

In the select family, the unit returns A when the condition holds. When it fails, the unit returns B unchanged, B plus one, the bitwise inverse of B, or the two's-complement negative of B. Conditional set writes 1 or all-ones when the condition holds, and zero otherwise. Conditional compare is the only operation that produces new flags. When the condition holds, these come from the subtraction A-B. When it fails, they come from a 4-bit immediate.

A narrow mode works on the low half of the operands only. It zero-extends the result and computes the compare flags at the narrow width. All outputs are registered. A result appears one cycle after it is accepted and is held until the next accepted operation.

Top module: `csel_unit`

## Requirements
- R1: The condition code selects a predicate on the flags: 0 Z, 1 not Z, 2 C, 3 not C, 4 N, 5 not N, 6 V, 7 not V, 8 C and not Z, 9 not C or Z, 10 N equals V, 11 N differs from V, 12 not Z and N equals V, 13 Z or N differs from V; codes 14 and 15 are always true. In the flags input, N is bit 3, Z is bit 2, C is bit 1 and V is bit 0.
- R2: Operation 0 (plain select), and the unused code 7, return A when the predicate holds and B otherwise.
- R3: Operation 1 returns A when the predicate holds and B+1 (wrapping) otherwise.
- R4: Operation 2 returns A when the predicate holds and the bitwise NOT of B otherwise.
- R5: Operation 3 returns A when the predicate holds and the two's-complement negation of B otherwise.
- R6: Operation 4 returns 1 when the predicate holds, and operation 5 returns all-ones when it holds. Both return 0 when it fails.
- R7: Operation 6 (conditional compare) returns result 0 and raises the flag-write output. When the predicate holds, the new flags are those of A-B: N is the sign of the difference, Z means the difference is zero, C means no borrow, and V means signed overflow.
- R8: Under operation 6, when the predicate fails, the new flags equal the immediate nibble, ordered N, Z, C, V from bit 3 down to bit 0.
- R9: Operations other than 6 leave the flag-write output low and present the incoming flags unchanged on the flags output.
- R10: With narrow mode set, bits 63..32 of the result are zero, values are formed from the low 32 bits of the operands, and compare flags are computed on 32-bit operands.
- R11: Results appear one clock after an accepted input. The valid output is the accept strobe delayed by one clock. While no input is accepted, the result, flags and flag-write outputs hold their values.
- R12: During reset, the valid output, the flag-write output, the result and the flags output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept strobe for the operation on the inputs |
| op | input | 3 | Operation code |
| cond | input | 4 | Condition code |
| narrow | input | 1 | 32-bit mode |
| opa | input | DATA_W (64) | Operand A |
| opb | input | DATA_W (64) | Operand B |
| imm_nzcv | input | 4 | Fallback flags for conditional compare |
| flags_in | input | 4 | Current N, Z, C, V flags |
| res_valid | output | 1 | Registered results are new this cycle |
| result | output | DATA_W (64) | Registered result |
| flags_out | output | 4 | Registered next flag state |
| flags_wr | output | 1 | Flags output must be written back |

## Verification
Conditional compare is where the two main functions of the unit meet in one cycle. The predicate reads the incoming flags while the subtractor produces a replacement set, and a wrong choice between the fresh flags and the immediate can easily slip through unnoticed. The bench provokes this by sweeping every condition against every flag state under compare. The operand pairs are chosen so that the subtraction flags and the immediate nibble always disagree. For each case, the registered flags are compared one cycle later with flags worked out arithmetically from the signed and unsigned orderings of the operands.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [2:0] {
    OP_SEL  = 3'd0,
    OP_SINC = 3'd1,
    OP_SINV = 3'd2,
    OP_SNEG = 3'd3,
    OP_SET1 = 3'd4,
    OP_SETM = 3'd5,
    OP_CCMP = 3'd6,
    OP_RSVD = 3'd7
  } csel_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
  import csel_pkg::*;
(
  input  logic [3:0] cond,
  input  nzcv_t      flags,
  output logic       holds
);

  logic base;

  // Even codes test the predicate, odd codes its inverse; 111x is always.
  always_comb begin
    unique case (cond[3:1])
      3'd0:    base = flags.z;
      3'd1:    base = flags.c;
      3'd2:    base = flags.n;
      3'd3:    base = flags.v;
      3'd4:    base = flags.c & ~flags.z;
      3'd5:    base = (flags.n == flags.v);
      3'd6:    base = ~flags.z & (flags.n == flags.v);
      default: base = 1'b1;
    endcase
    holds = (cond[3:1] == 3'b111) ? 1'b1 : (base ^ cond[0]);
  end

endmodule

// File: rtl/csel_fallback.sv
module csel_fallback
  import csel_pkg::*;
#(
  parameter int W = 64
) (
  input  csel_op_e       op,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   alt
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      OP_SINC: alt = b + ONE;
      OP_SINV: alt = ~b;
      OP_SNEG: alt = (~b) + ONE;
      default: alt = b;
    endcase
  end

endmodule

// File: rtl/csel_sub_flags.sv
module csel_sub_flags
  import csel_pkg::*;
#(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         narrow,
  output nzcv_t        flags
);

  logic [W:0] wsum;
  nzcv_t      wide_f;

  assign wsum = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};

  always_comb begin
    wide_f.n = wsum[W-1];
    wide_f.z = (wsum[W-1:0] == '0);
    wide_f.c = wsum[W];
    wide_f.v = (a[W-1] ^ b[W-1]) & (wsum[W-1] ^ a[W-1]);
  end

  generate
    if (NW < W) begin : g_narrow
      logic [NW:0] nsum;
      nzcv_t       nar_f;

      assign nsum = {1'b0, a[NW-1:0]} + {1'b0, ~b[NW-1:0]} + {{NW{1'b0}}, 1'b1};

      always_comb begin
        nar_f.n = nsum[NW-1];
        nar_f.z = (nsum[NW-1:0] == '0);
        nar_f.c = nsum[NW];
        nar_f.v = (a[NW-1] ^ b[NW-1]) & (nsum[NW-1] ^ a[NW-1]);
      end

      assign flags = narrow ? nar_f : wide_f;
    end else begin : g_wide_only
      assign flags = wide_f;
    end
  endgenerate

endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [3:0]        cond,
  input  logic              narrow,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [3:0]        imm_nzcv,
  input  logic [3:0]        flags_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags_out,
  output logic              flags_wr
);

  localparam int HI_W = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  csel_op_e          op_e;
  nzcv_t             cur_f;
  nzcv_t             cmp_f;
  logic              holds;
  logic [DATA_W-1:0] alt_b;
  logic [DATA_W-1:0] raw_res;
  logic [DATA_W-1:0] res_d;
  nzcv_t             flags_d;
  logic              wr_d;

  logic [DATA_W-1:0] res_q;
  nzcv_t             flags_q;
  logic              wr_q;
  logic              valid_q;

  assign op_e  = csel_op_e'(op);
  assign cur_f = nzcv_t'(flags_in);

  csel_cond_eval u_cond (
    .cond  (cond),
    .flags (cur_f),
    .holds (holds)
  );

  csel_fallback #(.W(DATA_W)) u_alt (
    .op  (op_e),
    .b   (opb),
    .alt (alt_b)
  );

  csel_sub_flags #(.W(DATA_W), .NW(NARROW_W)) u_cmp (
    .a      (opa),
    .b      (opb),
    .narrow (narrow),
    .flags  (cmp_f)
  );

  // Next-state selection.
  always_comb begin
    raw_res = '0;
    flags_d = cur_f;
    wr_d    = 1'b0;
    unique case (op_e)
      OP_SET1: raw_res = holds ? ONE : '0;
      OP_SETM: raw_res = holds ? '1 : '0;
      OP_CCMP: begin
        raw_res = '0;
        wr_d    = 1'b1;
        flags_d = holds ? cmp_f : nzcv_t'(imm_nzcv);
      end
      default: raw_res = holds ? opa : alt_b;
    endcase
  end

  generate
    if (NARROW_W < DATA_W) begin : g_zext
      assign res_d = narrow ? {{HI_W{1'b0}}, raw_res[NARROW_W-1:0]} : raw_res;
    end else begin : g_full
      assign res_d = raw_res;
    end
  endgenerate

  // Output registers, loaded only on an accepted operation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
      wr_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q   <= res_d;
        flags_q <= flags_d;
        wr_q    <= wr_d;
      end
    end
  end

  assign res_valid = valid_q;
  assign result    = res_q;
  assign flags_out = flags_q;
  assign flags_wr  = wr_q;

endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic              narrow,
  input logic [3:0]        flags_in,
  input logic              res_valid,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags_out,
  input logic              flags_wr
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!res_valid && !flags_wr && result == '0 && flags_out == '0); // R12
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    1'b1 |=> res_valid == $past(in_valid)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !in_valid |=> $stable(result) && $stable(flags_out) && $stable(flags_wr)); // R11

  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (in_valid && op != 3'd6) |=> (!flags_wr && flags_out == $past(flags_in))); // R9

  AST_CCMP_WRITES: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (in_valid && op == 3'd6) |=> (flags_wr && result == '0)); // R7

  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (in_valid && narrow) |=> ((result >> NARROW_W) == '0)); // R10

  AST_SET_ONE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (in_valid && op == 3'd4) |=> ($countones(result) <= 1 && result[DATA_W-1:1] == '0)); // R6

  AST_SET_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (in_valid && op == 3'd5 && !narrow) |=> (result == '0 || result == '1)); // R6

endmodule

bind csel_unit csel_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .narrow    (narrow),
  .flags_in  (flags_in),
  .res_valid (res_valid),
  .result    (result),
  .flags_out (flags_out),
  .flags_wr  (flags_wr)
);

// File: tb/csel_unit_tb_top.sv
module csel_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int WATCHDOG_CYCLES = 150000;
  localparam int NPAIRS = 6;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [2:0]    op;
  logic [3:0]    cond;
  logic          narrow;
  logic [DW-1:0] opa;
  logic [DW-1:0] opb;
  logic [3:0]    imm_nzcv;
  logic [3:0]    flags_in;
  logic          res_valid;
  logic [DW-1:0] result;
  logic [3:0]    flags_out;
  logic          flags_wr;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] pa [NPAIRS];
  logic [DW-1:0] pb [NPAIRS];

  csel_unit #(.DATA_W(DW), .NARROW_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cond(cond),
    .narrow(narrow), .opa(opa), .opb(opb), .imm_nzcv(imm_nzcv),
    .flags_in(flags_in), .res_valid(res_valid), .result(result),
    .flags_out(flags_out), .flags_wr(flags_wr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (op=%0d cond=%0d flags=%b narrow=%0b)",
               req, act, exp, op, cond, flags_in, narrow);
    end
  endtask

  // Predicate table from R1, flags ordered N Z C V at bits 3..0.
  function automatic logic pred(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [DW-1:0] trim(input logic [DW-1:0] x, input logic nar);
    return nar ? {32'h0, x[31:0]} : x;
  endfunction

  function automatic logic [DW-1:0] exp_res(input logic [2:0] o, input logic h,
                                            input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic nar);
    logic [DW-1:0] r;
    case (o)
      3'd1:    r = h ? a : b + 64'd1;
      3'd2:    r = h ? a : ~b;
      3'd3:    r = h ? a : 64'd0 - b;
      3'd4:    r = h ? 64'd1 : 64'd0;
      3'd5:    r = h ? {DW{1'b1}} : 64'd0;
      3'd6:    r = 64'd0;
      default: r = h ? a : b;
    endcase
    return trim(r, nar);
  endfunction

  // Flags of A-B from the orderings of the operands (R7, R10).
  function automatic logic [3:0] cmp_flags(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input logic nar);
    logic [DW-1:0] ua, ub, d;
    logic signed [DW-1:0] sa, sb;
    logic n, z, cy, lt;
    if (nar) begin
      ua = {32'h0, a[31:0]};
      ub = {32'h0, b[31:0]};
      sa = {{32{a[31]}}, a[31:0]};
      sb = {{32{b[31]}}, b[31:0]};
      d  = ua - ub;
      n  = d[31];
      z  = (d[31:0] == 32'h0);
    end else begin
      ua = a; ub = b; sa = a; sb = b;
      d  = a - b;
      n  = d[DW-1];
      z  = (d == 64'h0);
    end
    cy = (ua >= ub);
    lt = (sa < sb);
    return {n, z, cy, n ^ lt};
  endfunction

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired after %0d cycles", WATCHDOG_CYCLES);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] last_res;
    logic [3:0]    last_flags;
    logic          last_wr;
    string         tag;

    pa[0] = 64'h0;                   pb[0] = 64'h0;
    pa[1] = 64'd5;                   pb[1] = 64'd7;
    pa[2] = 64'd7;                   pb[2] = 64'd5;
    pa[3] = 64'h8000_0000_0000_0000; pb[3] = 64'd1;
    pa[4] = 64'h7FFF_FFFF_FFFF_FFFF; pb[4] = 64'hFFFF_FFFF_FFFF_FFFF;
    pa[5] = 64'h1234_5678_8000_0000; pb[5] = 64'hFFFF_FFFF_0000_0001;

    rst_n = 1'b0; in_valid = 1'b0; op = '0; cond = '0; narrow = 1'b0;
    opa = '0; opb = '0; imm_nzcv = '0; flags_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 valid",  {63'h0, res_valid}, 64'd0);
    chk("R12 result", result, 64'd0);
    chk("R12 flags",  {60'h0, flags_out}, 64'd0);
    chk("R12 wr",     {63'h0, flags_wr}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle valid", {63'h0, res_valid}, 64'd0);

    last_res = '0; last_flags = '0; last_wr = 1'b0;
    for (int o = 0; o < 8; o++) begin
      for (int nr = 0; nr < 2; nr++) begin
        for (int c = 0; c < 16; c++) begin
          for (int f = 0; f < 16; f++) begin
            for (int p = 0; p < NPAIRS; p++) begin
              logic h;
              logic [3:0] cf;
              op = 3'(o); narrow = nr[0]; cond = 4'(c); flags_in = 4'(f);
              opa = pa[p]; opb = pb[p];
              cf = cmp_flags(pa[p], pb[p], nr[0]);
              imm_nzcv = ~cf;
              in_valid = 1'b1;
              h = pred(4'(c), 4'(f));
              @(negedge clk);
              case (o)
                1: tag = "R1 R3 result";
                2: tag = "R1 R4 result";
                3: tag = "R1 R5 result";
                4: tag = "R1 R6 set one";
                5: tag = "R1 R6 set mask";
                6: tag = "R7 result";
                default: tag = "R1 R2 result";
              endcase
              if (nr != 0) tag = {tag, " R10"};
              last_res = exp_res(3'(o), h, pa[p], pb[p], nr[0]);
              chk(tag, result, last_res);
              chk("R11 valid", {63'h0, res_valid}, 64'd1);
              if (o == 6) begin
                last_flags = h ? cf : ~cf;
                last_wr = 1'b1;
                chk(h ? "R7 compare flags" : "R8 immediate flags",
                    {60'h0, flags_out}, {60'h0, last_flags});
                chk("R7 wr", {63'h0, flags_wr}, 64'd1);
              end else begin
                last_flags = 4'(f);
                last_wr = 1'b0;
                chk("R9 flags kept", {60'h0, flags_out}, {60'h0, last_flags});
                chk("R9 no wr", {63'h0, flags_wr}, 64'd0);
              end
            end
          end
        end
        // Idle cycle: new inputs without accept must change nothing (R11).
        in_valid = 1'b0;
        op = 3'(7 - o); cond = 4'd14; narrow = ~nr[0];
        opa = 64'hDEAD_BEEF_CAFE_F00D; opb = 64'h0123_4567_89AB_CDEF;
        flags_in = 4'b0110; imm_nzcv = 4'b1001;
        @(negedge clk);
        chk("R11 hold valid",  {63'h0, res_valid}, 64'd0);
        chk("R11 hold result", result, last_res);
        chk("R11 hold flags",  {60'h0, flags_out}, {60'h0, last_flags});
        chk("R11 hold wr",     {63'h0, flags_wr}, {63'h0, last_wr});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule